// File: doc/BRIEF.md
# Falling-Edge Event Counter with Compare Interrupt

This block counts falling edges on an asynchronous event pin with an up counter whose width is set by a parameter. Each edge passes through a two-stage synchronizer, and an edge detector turns it into a single-cycle pulse. While the run bit is set and the mode register selects event counting, each such pulse adds one to the counter. The counter's next value is compared against a compare register. On a hit, the block raises a one-cycle interrupt, returns the counter to zero, and goes on counting later edges.

Software programs the block through a simple write port. The port addresses three registers: a mode register, a compare (match) register and a control register that holds the run bit. The mode register can be changed only while the block is stopped. One mode bit places a shadow register in front of the compare register. The shadow lets a new match value be written mid-count without disturbing the current period. The current count is always visible on a read-only output.

Top module: `evt_match_counter`

## Requirements
- R1: After reset, `count_o` is 0 and `irq_o` is 0. The run bit, mode register, compare register and shadow register are all 0.
- R2: Counting is enabled when the run bit is 1, mode bits [1:0] are 00 and mode bit 2 (external enable) is 1. In that state, each falling edge of `evt_in` adds one to `count_o`. Rising edges do not change the count.
- R3: While the run bit is 0, falling edges of `evt_in` leave `count_o` unchanged.
- R4: If mode bits [1:0] are not 00, or mode bit 2 is 0, falling edges leave `count_o` unchanged, even with the run bit at 1.
- R5: Suppose a counted edge would bring the count to the compare value. Then `count_o` becomes 0 and `irq_o` is 1 for exactly one clock in that same cycle, and counting continues on later edges. For example, a compare value of 0x10 gives one interrupt per 16 edges.
- R6: A compare value of 0 gives one interrupt every 256 counted edges, when the count wraps from 255.
- R7: Writing 0 to the run bit (select 2, data bit 0) stops counting and forces `count_o` to 0.
- R8: Writes to the mode register (select 0) while the run bit is 1 are ignored.
- R9: With mode bit 3 (double buffer) at 0, a write to the compare register (select 1) takes effect for the very next counted edge.
- R10: With mode bit 3 at 1 and the block running, a compare write goes only to the shadow register. The old value governs until the next match, and the new value governs the period after it.
- R11: With mode bit 3 at 1 and the block stopped, the shadow value is copied into the compare register within one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mode, 1 compare, 2 control, 3 unused |
| wr_data | input | CNT_W | Write data |
| evt_in | input | 1 | Asynchronous event pin; each level must be held at least two clocks |
| count_o | output | CNT_W | Current counter value |
| irq_o | output | 1 | One-cycle interrupt on a compare match |

## Verification
The bench times every interrupt against the index of the edge that caused it. A design that compared the current count instead of the incremented count would fire one edge late. A design whose zero compare value matched at reset would fire on the first edge instead of the 256th. Mode writes are tried while running, both to disable counting and to change the buffering. A missing lock would let counting stop or the compare value jump. With double buffering on, the compare value is rewritten mid-period; a design that skipped the shadow would interrupt at the new value one period too early. Edges are also sent while stopped or in a non-event mode, to catch a design that counts anyway.

// File: rtl/evt_pkg.sv
package evt_pkg;

  typedef enum logic [1:0] {
    SEL_MODE  = 2'b00,
    SEL_MATCH = 2'b01,
    SEL_CTRL  = 2'b10,
    SEL_NONE  = 2'b11
  } reg_sel_e;

  typedef struct packed {
    logic [3:0] rsvd;
    logic       dbuf;
    logic       ext_en;
    logic [1:0] op;
  } mode_t;

  localparam logic [1:0] OP_EVENT = 2'b00;
  localparam int         MODE_W   = 8;

endpackage

// File: rtl/evt_rst_sync.sv
module evt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_in,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;
  logic                   prev_d;
  logic                   sampled;

  assign sampled = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], evt_in};
    prev_d = sampled;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign fall = prev_q & ~sampled;

  // a detected fall cannot repeat on the next clock
  assert_fall_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/evt_cfg_regs.sv
module evt_cfg_regs
  import evt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             match_clr,
  output logic             run,
  output logic             cnt_en,
  output logic [CNT_W-1:0] cmp_val
);
  mode_t            mode_q, mode_d;
  logic             run_q, run_d;
  logic [CNT_W-1:0] shadow_q, shadow_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             wr_mode, wr_match, wr_ctrl;
  logic             mode_ld, shadow_ld, cmp_ld;

  always_comb begin
    wr_mode  = wr_en && (reg_sel_e'(wr_sel) == SEL_MODE);
    wr_match = wr_en && (reg_sel_e'(wr_sel) == SEL_MATCH);
    wr_ctrl  = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
  end

  always_comb begin
    mode_ld   = wr_mode && !run_q;
    mode_d    = mode_t'(wr_data[MODE_W-1:0]);
    run_d     = wr_ctrl ? wr_data[0] : run_q;
    shadow_ld = wr_match;
    shadow_d  = wr_data;
    cmp_ld    = 1'b0;
    cmp_d     = cmp_q;
    if (!mode_q.dbuf) begin
      cmp_ld = wr_match;
      cmp_d  = wr_data;
    end else if (!run_q || match_clr) begin
      cmp_ld = 1'b1;
      cmp_d  = shadow_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      run_q    <= 1'b0;
      shadow_q <= '0;
      cmp_q    <= '0;
    end else begin
      run_q <= run_d;
      if (mode_ld)   mode_q   <= mode_d;
      if (shadow_ld) shadow_q <= shadow_d;
      if (cmp_ld)    cmp_q    <= cmp_d;
    end
  end

  assign run     = run_q;
  assign cnt_en  = (mode_q.op == OP_EVENT) && mode_q.ext_en;
  assign cmp_val = cmp_q;

  assert_mode_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(mode_q));

  assert_dbuf_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.dbuf && run_q && !match_clr) |=> $stable(cmp_q));

  assert_stop_copy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.dbuf && !run_q) |=> (cmp_q == $past(shadow_q)));
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall,
  input  logic             run,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] count,
  output logic             irq,
  output logic             match_clr
);
  logic [CNT_W-1:0] count_q, count_d, count_nxt;
  logic             irq_q, irq_d;
  logic             step, hit, count_ld;

  always_comb begin
    step      = run && cnt_en && fall;
    count_nxt = count_q + 1'b1;
    hit       = step && (count_nxt == cmp_val);
    count_ld  = !run || step;
    if (!run || hit) count_d = '0;
    else             count_d = count_nxt;
    irq_d     = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= irq_d;
      if (count_ld) count_q <= count_d;
    end
  end

  assign count     = count_q;
  assign irq       = irq_q;
  assign match_clr = hit;

  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  assert_irq_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (count_q == '0));

  assert_stop_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count_q == '0));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(cnt_en && fall)) |=> (count_q == $past(count_q)));
endmodule

// File: rtl/evt_match_counter.sv
module evt_match_counter #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             evt_in,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  logic             rst_sync_n;
  logic             fall;
  logic             run;
  logic             cnt_en;
  logic             match_clr;
  logic [CNT_W-1:0] cmp_val;

  evt_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  evt_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .evt_in(evt_in),
    .fall  (fall)
  );

  evt_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .match_clr(match_clr),
    .run      (run),
    .cnt_en   (cnt_en),
    .cmp_val  (cmp_val)
  );

  evt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .fall     (fall),
    .run      (run),
    .cnt_en   (cnt_en),
    .cmp_val  (cmp_val),
    .count    (count_o),
    .irq      (irq_o),
    .match_clr(match_clr)
  );
endmodule

// File: tb/sim_evt_match_counter.sv
`timescale 1ns/1ps
module sim_evt_match_counter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic       evt_in;
  logic [7:0] count_o;
  logic       irq_o;

  always #4 clk = ~clk;

  evt_match_counter u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .evt_in(evt_in), .count_o(count_o), .irq_o(irq_o)
  );

  int nchk = 0;
  int nfail = 0;
  int edge_idx = 0;
  int exp_q[$];
  bit done = 0;

  // requirement model
  int m_cnt = 0, m_cmp = 0, m_shadow = 0, m_run = 0, m_en = 0, m_dbuf = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    end
  endtask

  task automatic wr(int sel, int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel[1:0]; wr_data = data[7:0];
    @(negedge clk);
    wr_en = 1'b0;
    if (sel == 0 && m_run == 0) begin
      m_en   = ((data & 3) == 0 && (data & 4) != 0) ? 1 : 0;
      m_dbuf = (data & 8) != 0 ? 1 : 0;
    end
    if (sel == 1) begin
      m_shadow = data;
      if (!m_dbuf) m_cmp = data;
    end
    if (sel == 2) begin
      m_run = data & 1;
      if (!m_run) m_cnt = 0;
    end
    if (m_dbuf && !m_run) m_cmp = m_shadow;
    repeat (2) @(negedge clk);
  endtask

  // driver: one falling then rising edge, pushes expected interrupt edges
  task automatic evt_pulse();
    @(negedge clk);
    evt_in = 1'b0;
    edge_idx++;
    if (m_run && m_en) begin
      if (((m_cnt + 1) & 255) == m_cmp) begin
        exp_q.push_back(edge_idx);
        m_cnt = 0;
        if (m_dbuf) m_cmp = m_shadow;
      end else m_cnt = (m_cnt + 1) & 255;
    end
    repeat (4) @(negedge clk);
    evt_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) evt_pulse();
  endtask

  task automatic chk_cnt(string tag);
    chk(count_o == m_cnt[7:0], tag, count_o, m_cnt);
  endtask

  task automatic drain(string tag);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  // monitor: pops expected interrupt edges
  always @(negedge clk) begin
    if (rst_n && irq_o) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected irq at edge", edge_idx, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(e == edge_idx, "R5 irq edge index", edge_idx, e);
        chk(count_o == 8'd0, "R5 count zero with irq", count_o, 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 200000, 0);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = 8'd0; evt_in = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(count_o == 0, "R1 count after reset", count_o, 0);
    chk(irq_o == 0, "R1 irq after reset", irq_o, 0);

    // R2 / R5: count and match at 0x10
    wr(0, 8'h04); wr(1, 8'h10); wr(2, 1);
    pulses(5);  chk_cnt("R2 count after 5 edges");
    pulses(11); chk_cnt("R5 count after 16 edges");
    drain("R5 irq after 16 edges");
    pulses(3);  chk_cnt("R5 counting resumes");

    // R7 / R3
    wr(2, 0); chk_cnt("R7 stop clears count");
    pulses(3); chk_cnt("R3 edges ignored when stopped");

    // R4: non-event modes
    wr(0, 8'h05); wr(2, 1); pulses(4); chk_cnt("R4 op field nonzero");
    wr(2, 0); wr(0, 8'h00); wr(2, 1); pulses(4); chk_cnt("R4 external enable off");
    wr(2, 0);

    // R8: mode lock while running
    wr(0, 8'h04); wr(1, 3); wr(2, 1);
    wr(0, 8'h00);
    pulses(2); chk_cnt("R8 mode write ignored while running");
    wr(0, 8'h08);
    pulses(1); drain("R8 irq at 3 with mode locked");
    wr(1, 7); pulses(3); chk_cnt("R8 dbuf write ignored, compare direct");

    // R9: direct compare write
    wr(2, 0); wr(1, 9); wr(2, 1);
    pulses(1); wr(1, 5);
    pulses(4); drain("R9 new compare used immediately");
    chk_cnt("R9 count after match");

    // R6: compare zero
    wr(2, 0); wr(1, 0); wr(2, 1);
    pulses(255); chk_cnt("R6 count at 255");
    drain("R6 no irq before wrap");
    pulses(1); drain("R6 irq on wrap"); chk_cnt("R6 count after wrap");

    // R10 / R11: double buffer
    wr(2, 0); wr(0, 8'h0C); wr(1, 4); wr(2, 1);
    pulses(2); wr(1, 6);
    pulses(1); chk_cnt("R10 old compare holds");
    pulses(1); drain("R10 irq at old compare");
    pulses(5); chk_cnt("R10 new compare pending");
    pulses(1); drain("R10 irq at new compare");
    wr(2, 0); wr(1, 2); wr(2, 1);
    pulses(2); drain("R11 stopped copy of shadow");
    chk_cnt("R11 count after match");

    repeat (4) @(negedge clk);
    drain("R5 no pending irq at end");
    summary();
    $finish;
  end
endmodule